// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time as packed BCD counters: seconds, minutes, hours, day of week, day of month, month and a four-digit year. The year is split into a century byte and a year-in-century byte. A single-cycle pulse at 128 Hz drives a 7-bit sub-second prescaler. When the prescaler wraps it advances the seconds, and that carry ripples up through the calendar. Month lengths are applied, and February takes 29 days whenever the two-digit year is a multiple of four.

Software reaches every counter through a word-indexed register port with a 16-bit data path. Narrow registers use the low byte, and the year register uses all 16 bits. Software stops the clock to load a new time and then restarts it. It can clear the prescaler and request a 30-second rounding of the seconds. A sticky carry flag is raised each time the seconds step, so a driver can tell when a multi-register read straddled a rollover and retry it. The register port is a plain strobe interface: it has no handshake and no back-pressure. A write completes at the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` combinationally.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset, the registers read as follows.
  - Indexes 0 to 4 (sub-second, seconds, minutes, hours, weekday) read 0.
  - Day (index 5) and month (index 6) read 0x01.
  - Year (index 7) reads 0x2000.
  - Both control registers (indexes 14 and 15) read 0.
  - `carry_irq` is low.
- R2: While run (bit 0 of index 15) is 1, each `tick` pulse advances the sub-second counter (index 0, values 0 to 127). The step from 127 to 0 advances the seconds by one.
- R3: Seconds and minutes wrap from 0x59 to 0x00 and hours wrap from 0x23 to 0x00, each carrying upward. When the hours wrap, the weekday (values 0 to 6) advances and wraps from 6 to 0.
- R4: When the hours wrap on the last day of the month, the day returns to 0x01 and the month advances.
  - April, June, September and November have 30 days.
  - February has 29 days when the binary value of the year-in-century byte is divisible by 4, and 28 days otherwise.
  - All other months have 31 days.
- R5: The month wraps from 0x12 to 0x01 and advances the year-in-century byte (low byte of index 7). That byte wraps from 0x99 to 0x00 and advances the century byte (high byte of index 7).
- R6: While run is 0, ticks are ignored and all counters hold their values.
- R7: Writes to indexes 1 to 7 load the counters only while run is 0. While run is 1 these writes are ignored.
- R8: The carry flag is bit 7 of index 14.
  - It is set on every seconds carry.
  - Writing 0 to bit 7 clears it, and writing 1 leaves it unchanged.
  - If a clearing write and a carry fall in the same cycle, the flag ends up set.
- R9: `carry_irq` is high exactly while both the carry flag and the carry interrupt enable (bit 4 of index 14) are 1.
- R10: Writing 1 to bit 1 of index 15 clears the sub-second counter. This bit always reads back 0.
- R11: Writing 1 to bit 2 of index 15 sets the seconds to 0x00. If the seconds were 0x30 or more, the minutes also advance by one, with the full carry chain above them. This bit always reads back 0.
- R12: Bit 3 of index 15 is a plain stored enable bit that reads back as written. Indexes 8 to 13 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 128 Hz |
| bus_addr | input | 4 | Register word index |
| bus_wr | input | 1 | Write strobe, effective at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The assertions check the following on every cycle:
- the prescaler clears after a reset request and holds when it has no advance;
- every counter is frozen while the clock is stopped, and writes made while running leave the counters alone;
- the carry flag follows every seconds carry;
- the month wraps from 12 to 1;
- an adjustment zeroes the seconds.

Month-length selection, the leap rule (including year 00), the century carry, the weekday wrap and the set-versus-clear collision on the carry flag depend on particular calendar states. Only the bench's preset vectors and directed scenarios reach those states and compare the full time against expected values.

// File: rtl/rtc_clock_pkg.sv
package rtc_clock_pkg;
  localparam int FIELD_N = 8;   // sec, min, hour, wday, day, month, year-lo, century
  localparam int IDX_SUBSEC = 0;
  localparam int IDX_YEAR   = 7;
  localparam int IDX_CTRL1  = 14;
  localparam int IDX_CTRL2  = 15;
  localparam int C1_FLAG    = 7;
  localparam int C1_IE      = 4;
  localparam int C2_RUN     = 0;
  localparam int C2_CLR     = 1;
  localparam int C2_ADJ     = 2;
  localparam int C2_EN      = 3;
  localparam int F_DAY      = 4;
  localparam int F_MON      = 5;
  localparam int F_YLO      = 6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic yr_is_leap(input logic [7:0] yr);
    logic [7:0] bin;
    bin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic leap);
    case (mon)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_low(input int i);
    return (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] field_high(input int i);
    case (i)
      0, 1: return 8'h59;
      2: return 8'h23;
      3: return 8'h06;
      5: return 8'h12;
      default: return 8'h99;
    endcase
  endfunction

  function automatic logic [7:0] field_init(input int i);
    case (i)
      4, 5: return 8'h01;
      7: return 8'h20;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step (
  input  logic [7:0] cur,
  input  logic [7:0] low,
  input  logic [7:0] high,
  output logic [7:0] nxt,
  output logic       wrap
);
  import rtc_clock_pkg::*;
  // >= keeps an out-of-range loaded value from running away
  assign wrap = (cur >= high);
  assign nxt  = wrap ? low : bcd_inc(cur);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             carry
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  assign carry = adv && !clr && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + 1'b1;
  end

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0)); // R10
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt)); // R6
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_clock_pkg::*;
#(
  parameter int N = FIELD_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_step,
  input  logic             adjust,
  input  logic [N-1:0]     wr_en,
  input  logic [N-1:0][7:0] wr_val,
  output logic [N-1:0][7:0] fields
);
  logic [N-1:0]      en_w;
  logic [N-1:0]      wrap_w;
  logic [N-1:0][7:0] nxt_w;
  logic [7:0]        day_top;
  logic              adj_min;

  assign day_top = month_len(fields[F_MON], yr_is_leap(fields[F_YLO]));
  assign adj_min = adjust && (fields[0] >= 8'h30);

  for (genvar i = 0; i < N; i++) begin : g_field
    localparam int PAR = (i == F_DAY) ? 2 : i - 1;
    localparam logic [7:0] LOW  = field_low(i);
    localparam logic [7:0] HIGH = field_high(i);
    localparam logic [7:0] INIT = field_init(i);
    logic [7:0] val_q;
    logic [7:0] top_w;

    if (i == F_DAY) begin : g_dyn
      assign top_w = day_top;
    end else begin : g_fix
      assign top_w = HIGH;
    end

    if (i == 0) begin : g_root
      assign en_w[i] = sec_step;
    end else if (i == 1) begin : g_min
      assign en_w[i] = (en_w[0] && wrap_w[0]) || adj_min;
    end else begin : g_chain
      assign en_w[i] = en_w[PAR] && wrap_w[PAR];
    end

    rtc_bcd_step u_step (
      .cur  (val_q),
      .low  (LOW),
      .high (top_w),
      .nxt  (nxt_w[i]),
      .wrap (wrap_w[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                 val_q <= INIT;
      else if (wr_en[i])          val_q <= wr_val[i];
      else if (adjust && i == 0)  val_q <= 8'h00;
      else if (en_w[i])           val_q <= nxt_w[i];
    end

    assign fields[i] = val_q;
  end

  AST_MONTH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w[F_MON] && !wr_en[F_MON] && fields[F_MON] == 8'h12) |=> (fields[F_MON] == 8'h01)); // R5
  AST_ADJ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (adjust && !wr_en[0]) |=> (fields[0] == 8'h00)); // R11
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_clock_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int SUB_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              carry_irq
);
  logic                    run_q, en_q, flag_q, ie_q;
  logic                    wr_c1, wr_c2, pre_clr, adjust, pre_adv, sec_step;
  logic [SUB_W-1:0]        sub_cnt;
  logic [FIELD_N-1:0]      f_wr;
  logic [FIELD_N-1:0][7:0] f_val;
  logic [FIELD_N-1:0][7:0] fields;
  logic                    time_addr;

  assign wr_c1     = bus_wr && (bus_addr == ADDR_W'(IDX_CTRL1));
  assign wr_c2     = bus_wr && (bus_addr == ADDR_W'(IDX_CTRL2));
  assign pre_clr   = wr_c2 && bus_wdata[C2_CLR];
  assign adjust    = wr_c2 && bus_wdata[C2_ADJ];
  assign pre_adv   = tick && run_q && !adjust;
  assign time_addr = (bus_addr >= ADDR_W'(1)) && (bus_addr <= ADDR_W'(IDX_YEAR));

  for (genvar i = 0; i < FIELD_N; i++) begin : g_wr
    localparam int IDX = (i < F_YLO) ? i + 1 : IDX_YEAR;
    assign f_wr[i]  = bus_wr && !run_q && (bus_addr == ADDR_W'(IDX));
    assign f_val[i] = (i == FIELD_N - 1) ? bus_wdata[15:8] : bus_wdata[7:0];
  end

  rtc_prescaler #(.CNT_W(SUB_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (pre_adv),
    .clr   (pre_clr),
    .cnt   (sub_cnt),
    .carry (sec_step)
  );

  rtc_calendar #(.N(FIELD_N)) u_cal (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_step (sec_step),
    .adjust   (adjust),
    .wr_en    (f_wr),
    .wr_val   (f_val),
    .fields   (fields)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
    end else begin
      if (wr_c2) begin
        run_q <= bus_wdata[C2_RUN];
        en_q  <= bus_wdata[C2_EN];
      end
      if (wr_c1) ie_q <= bus_wdata[C1_IE];
      if (sec_step)                         flag_q <= 1'b1;
      else if (wr_c1 && !bus_wdata[C1_FLAG]) flag_q <= 1'b0;
    end
  end

  assign carry_irq = flag_q && ie_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(IDX_SUBSEC): bus_rdata = DATA_W'(sub_cnt);
      ADDR_W'(1): bus_rdata = DATA_W'(fields[0]);
      ADDR_W'(2): bus_rdata = DATA_W'(fields[1]);
      ADDR_W'(3): bus_rdata = DATA_W'(fields[2]);
      ADDR_W'(4): bus_rdata = DATA_W'(fields[3]);
      ADDR_W'(5): bus_rdata = DATA_W'(fields[4]);
      ADDR_W'(6): bus_rdata = DATA_W'(fields[5]);
      ADDR_W'(IDX_YEAR): bus_rdata = DATA_W'({fields[7], fields[6]});
      ADDR_W'(IDX_CTRL1): begin
        bus_rdata[C1_FLAG] = flag_q;
        bus_rdata[C1_IE]   = ie_q;
      end
      ADDR_W'(IDX_CTRL2): begin
        bus_rdata[C2_RUN] = run_q;
        bus_rdata[C2_EN]  = en_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> flag_q); // R8
  AST_STOPPED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !bus_wr) |=> ($stable(fields) && $stable(sub_cnt))); // R6
  AST_RUN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && bus_wr && time_addr && !sec_step) |=> $stable(fields)); // R7
endmodule

// File: tb/rtc_bcd_clock_test.sv
module rtc_bcd_clock_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        carry_irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_bcd_clock uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .carry_irq(carry_irq)
  );

  // packed {year16, month, day, weekday, hour, min, sec}
  localparam int NV = 12;
  localparam logic [63:0] VIN [NV] = '{
    64'h2024_03_15_03_10_20_30,  // R2 plain second
    64'h2024_03_15_03_10_20_59,  // R3 minute carry
    64'h2024_03_15_06_23_59_59,  // R3 hour and weekday wrap
    64'h2023_02_28_02_23_59_59,  // R4 non-leap February
    64'h2024_02_28_03_23_59_59,  // R4 leap February day 29
    64'h2024_02_29_04_23_59_59,  // R4 leap February end
    64'h2024_04_30_02_23_59_59,  // R4 30-day month
    64'h2024_12_31_02_23_59_59,  // R5 year carry
    64'h2099_12_31_04_23_59_59,  // R5 century carry
    64'h2024_01_31_03_23_59_59,  // R4 31-day month
    64'h2100_02_28_00_23_59_59,  // R4 year 00 counts as leap
    64'h2024_09_30_01_23_59_59   // R4 BCD month 09 to 10
  };
  localparam logic [63:0] VEXP [NV] = '{
    64'h2024_03_15_03_10_20_31,
    64'h2024_03_15_03_10_21_00,
    64'h2024_03_16_00_00_00_00,
    64'h2023_03_01_03_00_00_00,
    64'h2024_02_29_04_00_00_00,
    64'h2024_03_01_05_00_00_00,
    64'h2024_05_01_03_00_00_00,
    64'h2025_01_01_03_00_00_00,
    64'h2100_01_01_05_00_00_00,
    64'h2024_02_01_04_00_00_00,
    64'h2100_02_29_01_00_00_00,
    64'h2024_10_01_02_00_00_00
  };
  localparam int VREQ [NV] = '{2, 3, 3, 4, 4, 4, 4, 5, 5, 4, 4, 4};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_time(input logic [63:0] v);
    for (int f = 0; f < 6; f++) wr(4'(f + 1), {8'h00, v[f*8 +: 8]});
    wr(4'd7, v[63:48]);
  endtask

  task automatic get_time(output logic [63:0] v);
    logic [15:0] d;
    for (int f = 0; f < 6; f++) begin
      rd(4'(f + 1), d);
      v[f*8 +: 8] = d[7:0];
    end
    rd(4'd7, d);
    v[63:48] = d;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] d;
    logic [63:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, d);  chk("R1 subsec", 64'(d), 64'h0);
    rd(4'd1, d);  chk("R1 sec", 64'(d), 64'h0);
    rd(4'd3, d);  chk("R1 hour", 64'(d), 64'h0);
    rd(4'd5, d);  chk("R1 day", 64'(d), 64'h01);
    rd(4'd6, d);  chk("R1 month", 64'(d), 64'h01);
    rd(4'd7, d);  chk("R1 year", 64'(d), 64'h2000);
    rd(4'd14, d); chk("R1 ctrl1", 64'(d), 64'h0);
    rd(4'd15, d); chk("R1 ctrl2", 64'(d), 64'h0);
    chk("R1 irq", 64'(carry_irq), 64'h0);

    // R6 stopped clock ignores ticks
    ticks(10);
    rd(4'd0, d); chk("R6 subsec held", 64'(d), 64'h0);
    rd(4'd1, d); chk("R6 sec held", 64'(d), 64'h0);

    // R2 prescaler counts while running
    wr(4'd15, 16'h0001);
    ticks(5);
    rd(4'd0, d); chk("R2 subsec five", 64'(d), 64'h5);

    // R7 writes ignored while running
    wr(4'd1, 16'h0045);
    rd(4'd1, d); chk("R7 sec write ignored", 64'(d), 64'h0);

    // R10 prescaler clear, reads back 0
    wr(4'd15, 16'h0003);
    rd(4'd0, d);  chk("R10 subsec cleared", 64'(d), 64'h0);
    rd(4'd15, d); chk("R10 clr bit reads 0", 64'(d), 64'h0001);

    // R8 carry flag set, write-1 keeps, write-0 clears
    ticks(128);
    rd(4'd1, d);  chk("R2 sec stepped", 64'(d), 64'h01);
    rd(4'd14, d); chk("R8 flag set", 64'(d), 64'h80);
    wr(4'd14, 16'h0080);
    rd(4'd14, d); chk("R8 write 1 keeps", 64'(d), 64'h80);
    wr(4'd14, 16'h0000);
    rd(4'd14, d); chk("R8 write 0 clears", 64'(d), 64'h00);

    // R9 interrupt follows flag and enable
    ticks(128);
    chk("R9 irq off without enable", 64'(carry_irq), 64'h0);
    wr(4'd14, 16'h0090);
    #1 chk("R9 irq on", 64'(carry_irq), 64'h1);
    wr(4'd14, 16'h0010);
    #1 chk("R9 irq off after clear", 64'(carry_irq), 64'h0);

    // R8 set wins over a same-cycle clear
    ticks(127);
    @(negedge clk);
    tick = 1'b1; bus_addr = 4'd14; bus_wdata = 16'h0010; bus_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; bus_wr = 1'b0;
    rd(4'd14, d); chk("R8 set beats clear", 64'(d), 64'h90);

    // R11 thirty-second adjustment
    wr(4'd15, 16'h0000);
    wr(4'd1, 16'h0045); wr(4'd2, 16'h0010);
    wr(4'd15, 16'h0004);
    rd(4'd1, d);  chk("R11 sec rounded", 64'(d), 64'h00);
    rd(4'd2, d);  chk("R11 min carried", 64'(d), 64'h11);
    rd(4'd15, d); chk("R11 adj bit reads 0", 64'(d), 64'h0);
    wr(4'd1, 16'h0029); wr(4'd2, 16'h0010);
    wr(4'd15, 16'h0004);
    rd(4'd1, d); chk("R11 sec below 30", 64'(d), 64'h00);
    rd(4'd2, d); chk("R11 min kept", 64'(d), 64'h10);
    set_time(64'h2024_12_31_02_23_59_45);
    wr(4'd15, 16'h0004);
    get_time(t); chk("R11 cascade", t, 64'h2025_01_01_03_00_00_00);

    // R12 enable bit storage, alarm slots inert
    wr(4'd15, 16'h0008);
    rd(4'd15, d); chk("R12 enable bit", 64'(d), 64'h08);
    wr(4'd9, 16'h0055);
    rd(4'd9, d);  chk("R12 alarm slot", 64'(d), 64'h0);

    // calendar vectors: load, run one full second, compare
    for (int k = 0; k < NV; k++) begin
      wr(4'd15, 16'h0000);
      set_time(VIN[k]);
      wr(4'd15, 16'h0002);
      wr(4'd14, 16'h0000);
      wr(4'd15, 16'h0001);
      ticks(128);
      wr(4'd15, 16'h0000);
      get_time(t);
      chk($sformatf("R%0d vector %0d", VREQ[k], k), t, VEXP[k]);
    end

    done = 1;
    finish_run();
  end
endmodule